// File: doc/BRIEF.md
# Backdoor Key Unlock Controller

This block holds the security state of a device. The options byte is sampled while reset is held. Its two low bits give the security field, and its two high bits give the key-enable field. The device reads as unsecured only when the security field holds binary 10.

When the key-enable field permits it, software can unsecure the device through a backdoor. Software first raises a key-access mode input. It then writes four 16-bit key words through the array write port, one to each consecutive word address starting at a key base address, and finally drops the mode input. If every word matched its stored counterpart, the effective security field reads 10 until the next reset. Any illegal step latches a locked state. That state ignores all further key traffic until reset, and the device stays secured.

The stored keys and the options byte are inputs, and this block never alters them. Each reset therefore re-derives the security state from the options byte. A debug special-mode indicator stops a completed sequence from taking effect.

Top module: `keyguard_unlock`

## Requirements
- R1: While reset is held, the block captures the options byte; the security field is bits [1:0] and the key-enable field is bits [7:6]. After reset, `sec_field` equals the captured bits [1:0], `secured` is 0 only when that value is 2'b10, and `locked` is 0.
- R2: Unless the captured key-enable field is 2'b10, the backdoor is off. Key-mode sessions and array writes then leave `sec_field` unchanged and never set `locked`.
- R3: With the backdoor on, the sequence runs as follows: raise `key_mode`, write the four stored words (word i at bits [16i+15:16i] of `stored_keys`) in order to addresses KEY_BASE+0, +2, +4 and +6, then drop `key_mode`. After this, `sec_field` reads 2'b10 and `secured` reads 0 from the cycle after the drop.
- R4: A key write whose data differs from the stored word for its slot sets `locked` one cycle later.
- R5: A key write to any address other than the next expected slot address sets `locked`.
- R6: A key word of 16'h0000 or 16'hFFFF sets `locked`, even when the stored word holds that value.
- R7: A fifth key write in the same session sets `locked`.
- R8: Dropping `key_mode` after fewer than four accepted words sets `locked`.
- R9: `locked` stays set until reset, and a correct sequence issued while locked does not unsecure the device.
- R10: `rd_invalid` is 1 exactly while `key_mode` is 1.
- R11: If `dbg_special` is 1 when `key_mode` drops after four good words, the device stays secured and unlocked. A later session with `dbg_special` at 0 can still unsecure it.
- R12: A reset after a successful unlock restores `sec_field` from the options byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; options byte captured while low |
| opt_byte | input | 8 | Options byte: [1:0] security field, [7:6] key-enable field |
| stored_keys | input | NKEYS*KEY_W | Stored key words, word i at [KEY_W*i +: KEY_W] |
| key_mode | input | 1 | Key-access mode bit |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | ADDR_W | Array write byte address |
| wr_data | input | KEY_W | Array write data word |
| dbg_special | input | 1 | Debug access in special single-chip mode |
| secured | output | 1 | 1 while the device is secured |
| sec_field | output | 2 | Effective security field |
| rd_invalid | output | 1 | Array reads return invalid data |
| locked | output | 1 | Unlock sequence locked until reset |

## Verification
A corrupted sequencer state or slot counter shows up at the ports within one clock of the offending write or mode drop. It appears as `locked` rising when it should not, or as `sec_field` flipping to 2'b10 after a sequence that was short, reordered or blocked by debug. A wrong capture of the options byte shows up in the first cycle after reset as a mismatched `sec_field`. Stuck-locked or wrongly-sticky behaviour only becomes visible across a reset, so the checks pair every lock with a following reset and a fresh session.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  typedef enum logic [1:0] {
    KG_IDLE   = 2'd0,
    KG_ARMED  = 2'd1,
    KG_LOCKED = 2'd2,
    KG_OPEN   = 2'd3
  } kg_state_e;

  localparam logic [1:0] SEC_OPEN_CODE  = 2'b10;
  localparam logic [1:0] KEYEN_ON_CODE  = 2'b10;

  function automatic logic sec_is_open(input logic [1:0] f);
    return f == SEC_OPEN_CODE;
  endfunction

  function automatic logic keyen_allows(input logic [1:0] f);
    return f == KEYEN_ON_CODE;
  endfunction
endpackage

// File: rtl/keyguard_sec_latch.sv
module keyguard_sec_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opt_byte,
  output logic [1:0] sec_q,
  output logic [1:0] keyen_q
);
  // options byte is sampled on every clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= opt_byte[1:0];
      keyen_q <= opt_byte[7:6];
    end
  end
endmodule

// File: rtl/keyguard_word_check.sv
module keyguard_word_check #(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned NKEYS  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_BASE = ADDR_W'('hFF00),
  localparam int unsigned CNT_W = $clog2(NKEYS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CNT_W-1:0]       slot,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [KEY_W-1:0]       wr_data,
  input  logic [NKEYS*KEY_W-1:0] stored_keys,
  output logic                   word_good
);
  localparam int unsigned STEP = KEY_W / 8;

  function automatic logic is_reserved(input logic [KEY_W-1:0] d);
    return (d == '0) || (d == '1);
  endfunction

  logic [NKEYS-1:0] slot_hit;

  for (genvar i = 0; i < NKEYS; i++) begin : g_slot
    assign slot_hit[i] = (slot == CNT_W'(i))
                      && (wr_addr == KEY_BASE + ADDR_W'(STEP * i))
                      && (wr_data == stored_keys[i*KEY_W +: KEY_W]);
  end

  assign word_good = (|slot_hit) && !is_reserved(wr_data);

  // R6: a reserved data pattern is never accepted as a key word
  a_r6_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_reserved(wr_data)) |-> !word_good);
endmodule

// File: rtl/keyguard_seq_fsm.sv
module keyguard_seq_fsm
  import keyguard_pkg::*;
#(
  parameter int unsigned NKEYS = 4,
  localparam int unsigned CNT_W = $clog2(NKEYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bd_en,
  input  logic             key_mode,
  input  logic             dbg_special,
  input  logic             wr_en,
  input  logic             word_good,
  output kg_state_e        st,
  output logic [CNT_W-1:0] slot
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NKEYS);

  logic all_in;
  assign all_in = (slot == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= KG_IDLE;
      slot <= '0;
    end else begin
      unique case (st)
        KG_IDLE: begin
          if (bd_en && key_mode) begin
            st   <= KG_ARMED;
            slot <= '0;
          end
        end
        KG_ARMED: begin
          if (!key_mode) begin
            if (!all_in)          st <= KG_LOCKED;
            else if (dbg_special) st <= KG_IDLE;
            else                  st <= KG_OPEN;
          end else if (wr_en) begin
            if (word_good) slot <= slot + 1'b1;
            else           st   <= KG_LOCKED;
          end
        end
        KG_LOCKED: st <= KG_LOCKED;
        KG_OPEN:   st <= KG_OPEN;
        default:   st <= KG_LOCKED;
      endcase
    end
  end

  // R9: once locked, only reset leaves the state
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KG_LOCKED) |=> (st == KG_LOCKED));
  // R2: with the backdoor disabled the sequencer never leaves idle
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bd_en |-> (st == KG_IDLE));
  // R8: an early mode drop locks
  a_r8_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KG_ARMED && !key_mode && slot != FULL) |=> (st == KG_LOCKED));
  // R3: the open state is only entered after four accepted words and a mode drop
  a_r3_open_after_four: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == KG_OPEN) |-> ($past(slot) == FULL && !$past(key_mode)));
endmodule

// File: rtl/keyguard_unlock.sv
module keyguard_unlock
  import keyguard_pkg::*;
#(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned NKEYS  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_BASE = ADDR_W'('hFF00)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             opt_byte,
  input  logic [NKEYS*KEY_W-1:0] stored_keys,
  input  logic                   key_mode,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [KEY_W-1:0]       wr_data,
  input  logic                   dbg_special,
  output logic                   secured,
  output logic [1:0]             sec_field,
  output logic                   rd_invalid,
  output logic                   locked
);
  localparam int unsigned CNT_W = $clog2(NKEYS + 1);

  logic [1:0]       sec_q;
  logic [1:0]       keyen_q;
  logic             bd_en;
  logic             word_good;
  logic [CNT_W-1:0] slot;
  kg_state_e        st;

  keyguard_sec_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .opt_byte(opt_byte),
    .sec_q   (sec_q),
    .keyen_q (keyen_q)
  );

  assign bd_en = keyen_allows(keyen_q);

  keyguard_word_check #(
    .KEY_W(KEY_W), .NKEYS(NKEYS), .ADDR_W(ADDR_W), .KEY_BASE(KEY_BASE)
  ) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .slot       (slot),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stored_keys(stored_keys),
    .word_good  (word_good)
  );

  keyguard_seq_fsm #(.NKEYS(NKEYS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bd_en      (bd_en),
    .key_mode   (key_mode),
    .dbg_special(dbg_special),
    .wr_en      (wr_en),
    .word_good  (word_good),
    .st         (st),
    .slot       (slot)
  );

  assign sec_field  = (st == KG_OPEN) ? SEC_OPEN_CODE : sec_q;
  assign secured    = !sec_is_open(sec_field);
  assign rd_invalid = key_mode;
  assign locked     = (st == KG_LOCKED);

  // R4: a rejected key write inside a session locks on the next cycle
  a_r4_bad_word_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KG_ARMED && key_mode && wr_en && !word_good) |=> locked);
  // R11: a mode drop under debug special mode never unsecures
  a_r11_debug_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KG_ARMED && !key_mode && dbg_special) |=> (st != KG_OPEN));
  // R9: the locked output stays high
  a_r9_locked_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: tb/keyguard_unlock_tb_top.sv
module keyguard_unlock_tb_top;
  localparam logic [15:0] KB = 16'hFF00;
  localparam logic [15:0] K0 = 16'h1234, K1 = 16'h5678, K2 = 16'h9ABC, K3 = 16'hDEF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opt_byte = 8'h80;
  logic [63:0] stored_keys = {K3, K2, K1, K0};
  logic        key_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        dbg_special = 1'b0;
  logic        secured;
  logic [1:0]  sec_field;
  logic        rd_invalid;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyguard_unlock dut_i (
    .clk(clk), .rst_n(rst_n), .opt_byte(opt_byte), .stored_keys(stored_keys),
    .key_mode(key_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_special(dbg_special), .secured(secured), .sec_field(sec_field),
    .rd_invalid(rd_invalid), .locked(locked)
  );

  typedef struct {
    string      tag;
    logic [1:0] sec;
    logic       lck;
    logic       rdi;
  } exp_t;
  exp_t sb[$];

  task automatic expect_st(input string tag, input logic [1:0] s, input logic l, input logic r);
    exp_t e;
    e.tag = tag; e.sec = s; e.lck = l; e.rdi = r;
    sb.push_back(e);
  endtask

  // monitor: compares after the edge that follows each pushed expectation
  always @(posedge clk) begin
    #5;
    while (sb.size() > 0) begin
      exp_t e;
      logic exp_secured;
      e = sb.pop_front();
      exp_secured = (e.sec != 2'b10);
      checks++;
      if (sec_field !== e.sec || secured !== exp_secured ||
          locked !== e.lck || rd_invalid !== e.rdi) begin
        errors++;
        $display("FAIL %s: got sec=%b secured=%b locked=%b rdinv=%b exp sec=%b secured=%b locked=%b rdinv=%b",
                 e.tag, sec_field, secured, locked, rd_invalid,
                 e.sec, exp_secured, e.lck, e.rdi);
      end
    end
  end

  task automatic do_reset(input logic [7:0] ob);
    @(negedge clk);
    rst_n = 1'b0; opt_byte = ob; key_mode = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    opt_byte = ~ob;  // changing the byte after reset must not matter
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    key_mode = v;
    @(negedge clk);
  endtask

  task automatic kwr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic good_four();
    kwr(KB + 16'd0, stored_keys[15:0]);
    kwr(KB + 16'd2, stored_keys[31:16]);
    kwr(KB + 16'd4, stored_keys[47:32]);
    kwr(KB + 16'd6, stored_keys[63:48]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, secured field 00, backdoor enabled
    do_reset(8'h80);
    expect_st("R1 reset secured", 2'b00, 1'b0, 1'b0);
    // R10 read-invalid follows key mode
    set_mode(1'b1);
    expect_st("R10 rd_invalid high", 2'b00, 1'b0, 1'b1);
    // R3 full correct sequence
    good_four();
    expect_st("R3 still secured before drop", 2'b00, 1'b0, 1'b1);
    set_mode(1'b0);
    expect_st("R3 unsecured after drop", 2'b10, 1'b0, 1'b0);
    // R12 reset restores from options byte
    do_reset(8'h80);
    expect_st("R12 reset re-secures", 2'b00, 1'b0, 1'b0);

    // R4 mismatching data
    set_mode(1'b1);
    kwr(KB, K0);
    kwr(KB + 16'd2, 16'h1111);
    expect_st("R4 mismatch locks", 2'b00, 1'b1, 1'b1);
    // R9 further correct traffic ignored while locked
    good_four();
    set_mode(1'b0);
    expect_st("R9 lock persists", 2'b00, 1'b1, 1'b0);
    set_mode(1'b1);
    good_four();
    set_mode(1'b0);
    expect_st("R9 second session ignored", 2'b00, 1'b1, 1'b0);
    do_reset(8'h80);
    expect_st("R9 reset clears lock", 2'b00, 1'b0, 1'b0);

    // R5 wrong order
    set_mode(1'b1);
    kwr(KB + 16'd2, K1);
    expect_st("R5 wrong order locks", 2'b00, 1'b1, 1'b1);
    set_mode(1'b0);
    do_reset(8'h80);

    // R6 reserved words even if stored key equals them
    stored_keys = {K3, K2, K1, 16'hFFFF};
    set_mode(1'b1);
    kwr(KB, 16'hFFFF);
    expect_st("R6 FFFF locks", 2'b00, 1'b1, 1'b1);
    set_mode(1'b0);
    do_reset(8'h80);
    stored_keys = {K3, K2, 16'h0000, K0};
    set_mode(1'b1);
    kwr(KB, K0);
    expect_st("R6 first word accepted", 2'b00, 1'b0, 1'b1);
    kwr(KB + 16'd2, 16'h0000);
    expect_st("R6 0000 locks", 2'b00, 1'b1, 1'b1);
    set_mode(1'b0);
    stored_keys = {K3, K2, K1, K0};
    do_reset(8'h80);

    // R7 fifth word
    set_mode(1'b1);
    good_four();
    expect_st("R7 four words no lock", 2'b00, 1'b0, 1'b1);
    kwr(KB, K0);
    expect_st("R7 fifth word locks", 2'b00, 1'b1, 1'b1);
    set_mode(1'b0);
    expect_st("R7 stays secured", 2'b00, 1'b1, 1'b0);
    do_reset(8'h80);

    // R8 early mode drop
    set_mode(1'b1);
    kwr(KB, K0);
    kwr(KB + 16'd2, K1);
    set_mode(1'b0);
    expect_st("R8 early drop locks", 2'b00, 1'b1, 1'b0);

    // R2 key-enable 01: backdoor off
    do_reset(8'h40);
    set_mode(1'b1);
    good_four();
    set_mode(1'b0);
    expect_st("R2 keyen 01 no unlock", 2'b00, 1'b0, 1'b0);
    // R2 key-enable 11, short session does not lock
    do_reset(8'hC1);
    set_mode(1'b1);
    kwr(KB, 16'h0000);
    set_mode(1'b0);
    expect_st("R2 keyen 11 no lock", 2'b01, 1'b0, 1'b0);

    // R11 debug special mode blocks the unlock
    do_reset(8'h80);
    dbg_special = 1'b1;
    set_mode(1'b1);
    good_four();
    set_mode(1'b0);
    expect_st("R11 debug keeps secured", 2'b00, 1'b0, 1'b0);
    dbg_special = 1'b0;
    set_mode(1'b1);
    good_four();
    set_mode(1'b0);
    expect_st("R11 later session unlocks", 2'b10, 1'b0, 1'b0);

    // R1 option byte variants
    do_reset(8'h02);
    expect_st("R1 option 10 unsecured", 2'b10, 1'b0, 1'b0);
    do_reset(8'h83);
    expect_st("R1 option 11 secured", 2'b11, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule